// File: doc/BRIEF.md
# Sequential Unsigned Multiply-Divide Unit

This block is the multicycle arithmetic unit of an 8-bit CPU datapath. It runs one of two unsigned operations. Multiply takes the high byte of a 16-bit register pair, the accumulator, and the low byte of the same pair, and forms their 16-bit product. Divide takes the whole pair as a 16-bit dividend and a separate 8-bit register as the divisor. It returns a 16-bit quotient and an 8-bit remainder. The surrounding core pulses `start` with the operands and the operation select, waits while `busy` is high, and collects the results on the cycle in which `done` pulses.

The latency of each operation is fixed. Multiply finishes 16 clocks after the accepting edge and divide finishes 25 clocks after it, whatever the operand values. Multiply is a shift-add engine that consumes one multiplier bit per clock. Divide is a restoring shift-subtract engine that produces one quotient bit per clock. The remaining cycles are idle padding.

A divisor of zero does not trap. The result is all ones in the quotient and the low dividend byte in the remainder, after the normal 25 cycles.

The controller has three states:
- IDLE waits for `start`. Transition START moves it to CALC and captures the operands.
- CALC steps the selected engine once per clock. Transition ITER_END moves it to WAIT after 8 multiply steps or 16 divide steps.
- WAIT counts out the remaining cycles. Transition FINISH moves it back to IDLE, writes the result registers and raises `done`.

Top module: `muldiv_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `busy` and `done` are 0 and `word_out` and `byte_out` are 0.
- R2: With `op_sel`=0 (multiply), the operation is accepted when `start` is 1 and `busy` is 0 at a rising edge. `word_out` becomes `pair_in[15:8]` × `pair_in[7:0]` as captured at that edge. `byte_out` becomes the captured `c_in`.
- R3: A multiply raises `done` on the 16th rising edge after the accepting edge. `busy` is 1 in every cycle in between.
- R4: With `op_sel`=1 (divide) and a nonzero divisor, `word_out` becomes floor(`pair_in` / `c_in`) and `byte_out` becomes `pair_in` mod `c_in`. Both use the operands captured at the accepting edge.
- R5: A divide raises `done` on the 25th rising edge after the accepting edge. `busy` is 1 in every cycle in between.
- R6: A divide by a `c_in` of 0 returns 0xFFFF on `word_out` and the captured `pair_in[7:0]` on `byte_out`, with the same 25-cycle latency.
- R7: While `busy` is 1, a `start` pulse is ignored, as are changes on `op_sel`, `pair_in` and `c_in`. The running operation keeps its latency and its result.
- R8: `done` is high for exactly one cycle, and `busy` is 0 in that cycle. A `start` given in the `done` cycle is accepted, so operations can run back to back.
- R9: `word_out` and `byte_out` change only on the edge that raises `done`. They hold their values in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, sampled only while idle |
| op_sel | input | 1 | 0 = multiply, 1 = divide |
| pair_in | input | 16 | Register pair: accumulator in [15:8], second byte in [7:0]; dividend for divide |
| c_in | input | 8 | Divisor register; passed through to `byte_out` by multiply |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle completion pulse; results valid in the same cycle |
| word_out | output | 16 | Product or quotient |
| byte_out | output | 8 | Remainder, or the divisor register for multiply |

## Verification
The bench builds the unit with its default parameters: an 8-bit data width, a multiply latency of 16 and a divide latency of 25. At these values every operand pair can occur, including the all-ones products, the dividend of 0xFFFF and the zero divisor. The two distinct fixed latencies can therefore be measured edge by edge. Random operations are mixed with directed extremes, back-to-back starts in the completion cycle, and operand or start noise injected while the unit is busy.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic {
        OP_MUL = 1'b0,
        OP_DIV = 1'b1
    } md_op_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_CALC = 2'd1,
        S_WAIT = 2'd2
    } md_state_e;

endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
    import muldiv_pkg::*;
#(
    parameter int MUL_ITER = 8,
    parameter int DIV_ITER = 16,
    parameter int MUL_LAT  = 16,
    parameter int DIV_LAT  = 25
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  md_op_e op_sel,
    output logic   busy,
    output logic   load,
    output logic   step_mul,
    output logic   step_div,
    output logic   finish,
    output md_op_e op_q
);
    // Each latency must exceed its iteration count by at least one cycle.
    localparam int LAT_MAX = (MUL_LAT > DIV_LAT) ? MUL_LAT : DIV_LAT;
    localparam int CW      = $clog2(LAT_MAX + 1);

    md_state_e       state_q, state_n;
    logic [CW-1:0]   cyc_q, cyc_n;
    logic [CW-1:0]   iter_lim, lat_lim;
    logic            step;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cyc_q   <= '0;
            op_q    <= OP_MUL;
        end else begin
            state_q <= state_n;
            cyc_q   <= cyc_n;
            if (load) begin
                op_q <= op_sel;
            end
        end
    end

    // Next state and outputs
    always_comb begin
        state_n  = state_q;
        cyc_n    = cyc_q;
        load     = 1'b0;
        step     = 1'b0;
        finish   = 1'b0;
        iter_lim = (op_q == OP_DIV) ? CW'(DIV_ITER) : CW'(MUL_ITER);
        lat_lim  = (op_q == OP_DIV) ? CW'(DIV_LAT)  : CW'(MUL_LAT);
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    load    = 1'b1;
                    cyc_n   = CW'(1);
                    state_n = S_CALC;
                end
            end
            S_CALC: begin
                step  = 1'b1;
                cyc_n = cyc_q + CW'(1);
                if (cyc_q == iter_lim) begin
                    state_n = S_WAIT;
                end
            end
            S_WAIT: begin
                if (cyc_q == lat_lim) begin
                    finish  = 1'b1;
                    cyc_n   = '0;
                    state_n = S_IDLE;
                end else begin
                    cyc_n = cyc_q + CW'(1);
                end
            end
            default: begin
                state_n = S_IDLE;
                cyc_n   = '0;
            end
        endcase
    end

    assign busy     = (state_q != S_IDLE);
    assign step_mul = step && (op_q == OP_MUL);
    assign step_div = step && (op_q == OP_DIV);

endmodule

// File: rtl/muldiv_mul_engine.sv
module muldiv_mul_engine #(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            step,
    input  logic [DW-1:0]   mcand_in,
    input  logic [DW-1:0]   mplier_in,
    output logic [2*DW-1:0] product
);
    logic [DW-1:0] mcand_q;
    logic [DW-1:0] hi_q;
    logic [DW-1:0] lo_q;
    logic [DW:0]   addend;
    logic [DW:0]   sum;

    // Add the multiplicand when the current multiplier bit is set.
    always_comb begin
        addend = lo_q[0] ? {1'b0, mcand_q} : '0;
        sum    = {1'b0, hi_q} + addend;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
        end else if (load) begin
            mcand_q <= mcand_in;
            hi_q    <= '0;
            lo_q    <= mplier_in;
        end else if (step) begin
            // The carry drops into the high half and the used bit leaves the low half.
            {hi_q, lo_q} <= {sum, lo_q[DW-1:1]};
        end
    end

    assign product = {hi_q, lo_q};

endmodule

// File: rtl/muldiv_div_engine.sv
module muldiv_div_engine #(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            step,
    input  logic [2*DW-1:0] dividend_in,
    input  logic [DW-1:0]   divisor_in,
    output logic [2*DW-1:0] quotient,
    output logic [DW-1:0]   remainder
);
    logic [DW-1:0]   dvs_q;
    logic [DW-1:0]   rem_q;
    logic [2*DW-1:0] quo_q;
    logic [DW:0]     trial;
    logic [DW:0]     diff;
    logic            fits;

    // Bring in the next dividend bit and try a subtraction.
    // A zero divisor always fits, which yields all ones and the low dividend byte.
    always_comb begin
        trial = {rem_q, quo_q[2*DW-1]};
        diff  = trial - {1'b0, dvs_q};
        fits  = (trial >= {1'b0, dvs_q});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvs_q <= '0;
            rem_q <= '0;
            quo_q <= '0;
        end else if (load) begin
            dvs_q <= divisor_in;
            rem_q <= '0;
            quo_q <= dividend_in;
        end else if (step) begin
            rem_q <= fits ? diff[DW-1:0] : trial[DW-1:0];
            quo_q <= {quo_q[2*DW-2:0], fits};
        end
    end

    assign quotient  = quo_q;
    assign remainder = rem_q;

endmodule

// File: rtl/muldiv_seq.sv
module muldiv_seq
    import muldiv_pkg::*;
#(
    parameter int DW      = 8,
    parameter int MUL_LAT = 16,
    parameter int DIV_LAT = 25
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            op_sel,
    input  logic [2*DW-1:0] pair_in,
    input  logic [DW-1:0]   c_in,
    output logic            busy,
    output logic            done,
    output logic [2*DW-1:0] word_out,
    output logic [DW-1:0]   byte_out
);
    localparam int MUL_ITER = DW;
    localparam int DIV_ITER = 2 * DW;

    logic            load, step_mul, step_div, finish;
    md_op_e          op_q;
    logic [2*DW-1:0] product, quotient;
    logic [DW-1:0]   remainder;
    logic [DW-1:0]   side_q;
    logic [2*DW-1:0] word_q;
    logic [DW-1:0]   byte_q;
    logic            done_q;

    muldiv_ctrl #(
        .MUL_ITER (MUL_ITER),
        .DIV_ITER (DIV_ITER),
        .MUL_LAT  (MUL_LAT),
        .DIV_LAT  (DIV_LAT)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op_sel   (md_op_e'(op_sel)),
        .busy     (busy),
        .load     (load),
        .step_mul (step_mul),
        .step_div (step_div),
        .finish   (finish),
        .op_q     (op_q)
    );

    muldiv_mul_engine #(.DW(DW)) u_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step_mul),
        .mcand_in  (pair_in[2*DW-1:DW]),
        .mplier_in (pair_in[DW-1:0]),
        .product   (product)
    );

    muldiv_div_engine #(.DW(DW)) u_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .step        (step_div),
        .dividend_in (pair_in),
        .divisor_in  (c_in),
        .quotient    (quotient),
        .remainder   (remainder)
    );

    // Result registers change only on the finishing edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            side_q <= '0;
            word_q <= '0;
            byte_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
            if (load) begin
                side_q <= c_in;
            end
            if (finish) begin
                word_q <= (op_q == OP_DIV) ? quotient  : product;
                byte_q <= (op_q == OP_DIV) ? remainder : side_q;
            end
        end
    end

    assign done     = done_q;
    assign word_out = word_q;
    assign byte_out = byte_q;

endmodule

// File: rtl/muldiv_checker.sv
module muldiv_checker #(
    parameter int DW      = 8,
    parameter int MUL_LAT = 16,
    parameter int DIV_LAT = 25
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            op_sel,
    input logic [2*DW-1:0] pair_in,
    input logic [DW-1:0]   c_in,
    input logic            busy,
    input logic            done,
    input logic [2*DW-1:0] word_out,
    input logic [DW-1:0]   byte_out
);
    logic [2*DW-1:0] cap_pair;
    logic [DW-1:0]   cap_c;
    logic            cap_op;
    logic            armed;
    int unsigned     elapsed;
    int unsigned     exp_lat;
    logic [3*DW-1:0] recomb;
    logic [2*DW-1:0] mul_ref;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_pair <= '0;
            cap_c    <= '0;
            cap_op   <= 1'b0;
            armed    <= 1'b0;
            elapsed  <= 0;
        end else if (start && !busy) begin
            cap_pair <= pair_in;
            cap_c    <= c_in;
            cap_op   <= op_sel;
            armed    <= 1'b1;
            elapsed  <= 0;
        end else if (busy) begin
            elapsed  <= elapsed + 1;
        end
    end

    always_comb begin
        exp_lat = cap_op ? unsigned'(DIV_LAT) : unsigned'(MUL_LAT);
        recomb  = (3*DW)'(word_out) * (3*DW)'(cap_c) + (3*DW)'(byte_out);
        mul_ref = (2*DW)'(cap_pair[2*DW-1:DW]) * (2*DW)'(cap_pair[DW-1:0]);
    end

    p_mul_product_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cap_op) |-> (word_out == mul_ref) && (byte_out == cap_c));

    p_mul_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cap_op) |-> (elapsed == unsigned'(MUL_LAT)));

    p_div_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_op && (cap_c != '0)) |->
            (recomb == (3*DW)'(cap_pair)) && (byte_out < cap_c));

    p_div_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_op) |-> (elapsed == unsigned'(DIV_LAT)));

    p_div_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_op && (cap_c == '0)) |->
            (word_out == '1) && (byte_out == cap_pair[DW-1:0]));

    p_busy_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (elapsed < exp_lat));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && armed));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(word_out) && $stable(byte_out)));

endmodule

bind muldiv_seq muldiv_checker #(
    .DW      (DW),
    .MUL_LAT (MUL_LAT),
    .DIV_LAT (DIV_LAT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op_sel   (op_sel),
    .pair_in  (pair_in),
    .c_in     (c_in),
    .busy     (busy),
    .done     (done),
    .word_out (word_out),
    .byte_out (byte_out)
);

// File: tb/sim_muldiv_seq.sv
`timescale 1ns/1ps
module sim_muldiv_seq;
    localparam int MUL_LAT = 16;
    localparam int DIV_LAT = 25;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_sel = 1'b0;
    logic [15:0] pair_in = '0;
    logic [7:0]  c_in = '0;
    logic        busy, done;
    logic [15:0] word_out;
    logic [7:0]  byte_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    muldiv_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
        .pair_in(pair_in), .c_in(c_in), .busy(busy), .done(done),
        .word_out(word_out), .byte_out(byte_out)
    );

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input bit op, input logic [15:0] p,
                                             input logic [7:0] c);
        if (!op) return 16'(p[15:8]) * 16'(p[7:0]);
        if (c == 0) return 16'hFFFF;
        return p / 16'(c);
    endfunction

    function automatic logic [7:0] exp_byte(input bit op, input logic [15:0] p,
                                            input logic [7:0] c);
        if (!op) return c;
        if (c == 0) return p[7:0];
        return 8'(p % 16'(c));
    endfunction

    // Called at a negative edge; returns at the negative edge that shows done.
    task automatic run_op(input bit op, input logic [15:0] pr, input logic [7:0] c,
                          input bit noisy, input string rq);
        int k;
        int busy_bad;
        string rl;
        rl = op ? "R5" : "R3";
        op_sel = op; pair_in = pr; c_in = c; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        if (noisy) begin
            pair_in = ~pr; c_in = c + 8'd1; op_sel = ~op;
        end
        @(negedge clk);
        k = 0; busy_bad = 0;
        while (!done && k < 200) begin
            if (!busy) busy_bad++;
            if (noisy && k == 3) start = 1'b1;
            if (noisy && k == 4) start = 1'b0;
            @(negedge clk);
            k++;
        end
        chk(rl, "latency", k, op ? DIV_LAT : MUL_LAT);
        chk(rl, "busy gaps", busy_bad, 0);
        chk("R8", "busy in done cycle", busy, 0);
        chk(rq, "word", word_out, exp_word(op, pr, c));
        chk(rq, "byte", byte_out, exp_byte(op, pr, c));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] held_w;
        logic [7:0]  held_b;
        void'($urandom(32'd7177));
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1", "busy in reset", busy, 0);
        chk("R1", "done in reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy after reset", busy, 0);
        chk("R1", "done after reset", done, 0);
        chk("R1", "word after reset", word_out, 0);
        chk("R1", "byte after reset", byte_out, 0);

        // Directed corners
        run_op(1'b0, 16'hFFFF, 8'h3C, 1'b0, "R2");
        run_op(1'b0, 16'h007B, 8'h00, 1'b0, "R2");
        run_op(1'b0, 16'h8001, 8'hA5, 1'b0, "R2");
        run_op(1'b1, 16'hFFFF, 8'h01, 1'b0, "R4");
        run_op(1'b1, 16'h1234, 8'hFF, 1'b0, "R4");
        run_op(1'b1, 16'h0005, 8'h09, 1'b0, "R4");
        run_op(1'b1, 16'hFFFF, 8'hFF, 1'b0, "R4");
        run_op(1'b1, 16'hABCD, 8'h00, 1'b0, "R6");
        run_op(1'b1, 16'h0000, 8'h00, 1'b0, "R6");

        // R8 back to back: start given in the done cycle is accepted
        run_op(1'b1, 16'h4321, 8'h07, 1'b0, "R8");
        run_op(1'b0, 16'h0F0F, 8'h11, 1'b0, "R8");
        run_op(1'b1, 16'h0100, 8'h00, 1'b0, "R8");

        // R9 hold and R8 single pulse
        held_w = word_out; held_b = byte_out;
        pair_in = 16'h5555; c_in = 8'h33; op_sel = 1'b0;
        @(negedge clk);
        chk("R8", "done one cycle", done, 0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R9", "word held", word_out, held_w);
            chk("R9", "byte held", byte_out, held_b);
        end

        // R7 noise while busy
        run_op(1'b0, 16'hC3A7, 8'h19, 1'b1, "R7");
        run_op(1'b1, 16'hBEEF, 8'h2D, 1'b1, "R7");
        run_op(1'b1, 16'h7E57, 8'h00, 1'b1, "R7");

        // Random mix
        for (int n = 0; n < 300; n++) begin
            bit op;
            logic [15:0] pr;
            logic [7:0] c;
            string rq;
            op = 1'($urandom);
            pr = 16'($urandom);
            c  = (($urandom % 8) == 0) ? 8'h00 : 8'($urandom);
            rq = op ? ((c == 0) ? "R6" : "R4") : "R2";
            if (($urandom % 4) == 0) rq = "R7";
            run_op(op, pr, c, (rq == "R7"), rq);
            if (($urandom % 3) == 0) begin
                held_w = word_out; held_b = byte_out;
                repeat (1 + ($urandom % 4)) @(negedge clk);
                chk("R9", "word held idle", word_out, held_w);
                chk("R9", "byte held idle", byte_out, held_b);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule